// File: doc/BRIEF.md
# Modulo-64 Compression Quotient Channel

This block is the narrow side channel of a residue-number-system datapath whose wide channels use odd moduli near 2^W. It works modulo 64. When a pair (K, R) of multiplication outputs has grown too large, the block computes the two small quotient digits Kk ≈ K / M_a and Kr ≈ R / M_a, where M_a is the product of the source-base moduli. These digits are below 64, so every wide channel can take them directly. The channel also produces its own modulo-64 lane of the compressed pair.

For each operand the block takes two inputs from the wide channels: the scaled residues xi_i = |x_i · (M_a/m_i)^-1|_{m_i}, one per source modulus, and the operand's own residue modulo 64. It then performs a base extension onto the single modulus 64. The CRT quotient is estimated from the six top bits of each xi_i. After the extension it subtracts and multiplies by M_a^-1 mod 64. Because the modulus is a power of two, every reduction is a truncation to six bits.

The block accepts one operand pair per cycle. The pipeline has six register stages, the same depth as the wide channels. All modulo-64 constants are derived at elaboration from the moduli parameter.

Top module: `gchan_compress`

## Requirements
- R1: While `rst` is high at a rising edge, the following outputs are zero after that edge: `out_valid`, `k_quot`, `r_quot`, `kc_g` and `rc_g`.
- R2: Each input cycle with `in_valid` high produces exactly one output cycle with `out_valid` high, six rising edges later. Results stay in order, back-to-back inputs are accepted, and no output appears for an idle cycle.
- R3: The extended residue of K is Rk^ = (sum_i xi_i·(M_a/m_i) − q^·M_a) mod 64. The estimate is q^ = floor((SIGMA0 + sum_i top6(xi_i)) / 64), where top6 means bits [W−1:W−6] of xi_i.
- R4: The low six bits of `k_quot` equal ((K mod 64) − Rk^) · (M_a^-1 mod 64) mod 64. For K < 63·M_a and an exact estimate, this equals floor(K / M_a).
- R5: `r_quot` is formed from the R inputs in the same way as `k_quot` is formed from K, and it does not depend on the K inputs.
- R6: Bits [W−1:6] of `k_quot` and `r_quot` are always zero.
- R7: `kc_g` = (Kr + Rk^) mod 64 and `rc_g` = (Rr^ + 2·Kk) mod 64. This is the modulo-64 lane of the compressed pair.
- R8: When q^ falls one below the exact CRT quotient, the digit becomes floor(K/M_a) − 1 mod 64. For K < M_a this wraps to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present this cycle |
| k_xi | input | NA*W | Scaled source residues of K, modulus i in bits [i*W +: W] |
| k_g | input | 6 | K mod 64 |
| r_xi | input | NA*W | Scaled source residues of R |
| r_g | input | 6 | R mod 64 |
| out_valid | output | 1 | Result present this cycle |
| k_quot | output | W | Kk, zero-padded to W bits |
| r_quot | output | W | Kr, zero-padded to W bits |
| kc_g | output | 6 | Compressed K-part residue modulo 64 |
| rc_g | output | 6 | Compressed R-part residue modulo 64 |

## Verification
The assertions check three things on every cycle. They check the reset clearing of the outputs. They check the fixed six-edge relation between `in_valid` and `out_valid`. They also check that each output digit, multiplied by M_a and added to the extended residue, gives back the operand's own residue modulo 64.

Only the bench's scenarios can show that the digit equals the true quotient floor(K/M_a). The bench also covers the estimate falling short by one and wrapping to 63, the operand boundaries 0, M_a−1, M_a and 63·M_a−1, and the combined lanes `kc_g` and `rc_g`. The reference for all of these is computed with exact integer division.

// File: rtl/gchan_pkg.sv
package gchan_pkg;

    localparam int G_BITS = 6;

    typedef logic [G_BITS-1:0] gres_t;

    // one operand travelling down the channel: extended residue and own residue
    typedef struct packed {
        gres_t rk;
        gres_t res;
    } glane_t;

    function automatic gres_t g_mul(input gres_t a, input gres_t b);
        logic [2*G_BITS-1:0] p;
        p = a * b;
        return p[G_BITS-1:0];
    endfunction

    function automatic gres_t g_add(input gres_t a, input gres_t b);
        return a + b;
    endfunction

    // inverse of an odd value modulo 64, found by search at elaboration
    function automatic gres_t g_inv(input gres_t a);
        gres_t r;
        r = '0;
        for (int c = 1; c < (1 << G_BITS); c += 2) begin
            if (g_mul(a, gres_t'(c)) == gres_t'(1)) r = gres_t'(c);
        end
        return r;
    endfunction

endpackage

// File: rtl/gchan_ext_lane.sv
module gchan_ext_lane
    import gchan_pkg::*;
#(
    parameter int             W      = 16,
    parameter int             NA     = 3,
    parameter logic [NA*6-1:0] COF_G = '0,
    parameter gres_t          MA_G   = '0,
    parameter gres_t          SIGMA0 = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NA*W-1:0] xi,
    input  gres_t           res_i,
    output glane_t          lane_o
);
    localparam int QW  = $clog2(NA + 1);
    localparam int MSW = G_BITS + QW;

    // stage 1: per-modulus product modulo 64 and top-six-bit truncation
    gres_t prod_q [NA];
    gres_t top_q  [NA];
    gres_t res1_q;

    for (genvar i = 0; i < NA; i++) begin : g_term
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q[i] <= '0;
                top_q[i]  <= '0;
            end else begin
                prod_q[i] <= gres_t'(xi[i*W +: W] * {{(W-G_BITS){1'b0}}, COF_G[i*G_BITS +: G_BITS]});
                top_q[i]  <= xi[i*W + W - 1 -: G_BITS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res1_q <= '0;
        else     res1_q <= res_i;
    end

    // stage 2: accumulate products and the quotient estimate
    gres_t          psum;
    logic [MSW-1:0] msum;
    gres_t          psum_q;
    logic [QW-1:0]  qhat_q;
    gres_t          res2_q;

    always_comb begin
        psum = '0;
        msum = MSW'(SIGMA0);
        for (int i = 0; i < NA; i++) begin
            psum = g_add(psum, prod_q[i]);
            msum = msum + MSW'(top_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psum_q <= '0;
            qhat_q <= '0;
            res2_q <= '0;
        end else begin
            psum_q <= psum;
            qhat_q <= QW'(msum >> G_BITS);
            res2_q <= res1_q;
        end
    end

    // stage 3: remove the estimated multiple of M_a
    always_ff @(posedge clk) begin
        if (rst) lane_o <= '0;
        else     lane_o <= '{rk: psum_q - g_mul(gres_t'(qhat_q), MA_G), res: res2_q};
    end

endmodule

// File: rtl/gchan_quot_lane.sv
module gchan_quot_lane
    import gchan_pkg::*;
#(
    parameter gres_t MA_INV_G = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  glane_t lane_i,
    output gres_t  quot_o,
    output glane_t lane_o
);
    gres_t  diff_q;
    glane_t lane4_q;

    // stage 4: own residue minus extended residue
    always_ff @(posedge clk) begin
        if (rst) begin
            diff_q  <= '0;
            lane4_q <= '0;
        end else begin
            diff_q  <= lane_i.res - lane_i.rk;
            lane4_q <= lane_i;
        end
    end

    // stage 5: exact division by M_a modulo 64
    always_ff @(posedge clk) begin
        if (rst) begin
            quot_o <= '0;
            lane_o <= '0;
        end else begin
            quot_o <= g_mul(diff_q, MA_INV_G);
            lane_o <= lane4_q;
        end
    end

endmodule

// File: rtl/gchan_compress.sv
module gchan_compress
    import gchan_pkg::*;
#(
    parameter int              W       = 16,
    parameter int              NA      = 3,
    parameter logic [NA*W-1:0] MODULI  = {16'd65497, 16'd65519, 16'd65521},
    parameter gres_t           SIGMA0  = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [NA*W-1:0] k_xi,
    input  logic [5:0]      k_g,
    input  logic [NA*W-1:0] r_xi,
    input  logic [5:0]      r_g,
    output logic            out_valid,
    output logic [W-1:0]    k_quot,
    output logic [W-1:0]    r_quot,
    output logic [5:0]      kc_g,
    output logic [5:0]      rc_g
);
    localparam int DEPTH = 6;

    function automatic gres_t ma_mod_g();
        gres_t acc;
        acc = gres_t'(1);
        for (int i = 0; i < NA; i++) acc = g_mul(acc, MODULI[i*W +: G_BITS]);
        return acc;
    endfunction

    function automatic logic [NA*6-1:0] cof_mod_g();
        logic [NA*6-1:0] v;
        gres_t acc;
        for (int i = 0; i < NA; i++) begin
            acc = gres_t'(1);
            for (int j = 0; j < NA; j++)
                if (j != i) acc = g_mul(acc, MODULI[j*W +: G_BITS]);
            v[i*G_BITS +: G_BITS] = acc;
        end
        return v;
    endfunction

    localparam gres_t           MA_G     = ma_mod_g();
    localparam logic [NA*6-1:0] COF_G    = cof_mod_g();
    localparam gres_t           MA_INV_G = g_inv(MA_G);

    logic [NA*W-1:0] xi_in  [2];
    gres_t           res_in [2];
    glane_t          ext_l  [2];
    glane_t          q_l    [2];
    gres_t           quot   [2];

    assign xi_in[0]  = k_xi;
    assign xi_in[1]  = r_xi;
    assign res_in[0] = k_g;
    assign res_in[1] = r_g;

    for (genvar op = 0; op < 2; op++) begin : g_op
        gchan_ext_lane #(
            .W(W), .NA(NA), .COF_G(COF_G), .MA_G(MA_G), .SIGMA0(SIGMA0)
        ) ext_i (
            .clk(clk), .rst(rst), .xi(xi_in[op]), .res_i(res_in[op]), .lane_o(ext_l[op])
        );
        gchan_quot_lane #(.MA_INV_G(MA_INV_G)) quot_i (
            .clk(clk), .rst(rst), .lane_i(ext_l[op]), .quot_o(quot[op]), .lane_o(q_l[op])
        );
    end

    // stage 6: output register and compressed-pair lane
    logic [DEPTH-1:0] vld_q;
    gres_t            kk_q, kr_q, kc_q, rc_q;
    glane_t           k6_q, r6_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            kk_q  <= '0;
            kr_q  <= '0;
            kc_q  <= '0;
            rc_q  <= '0;
            k6_q  <= '0;
            r6_q  <= '0;
        end else begin
            vld_q <= {vld_q[DEPTH-2:0], in_valid};
            kk_q  <= quot[0];
            kr_q  <= quot[1];
            kc_q  <= g_add(quot[1], q_l[0].rk);
            rc_q  <= g_add(q_l[1].rk, g_add(quot[0], quot[0]));
            k6_q  <= q_l[0];
            r6_q  <= q_l[1];
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign k_quot    = {{(W-G_BITS){1'b0}}, kk_q};
    assign r_quot    = {{(W-G_BITS){1'b0}}, kr_q};
    assign kc_g      = kc_q;
    assign rc_g      = rc_q;

    // edges seen since reset, saturating, for the latency check
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)               age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && k_quot == '0 && r_quot == '0 && kc_g == '0 && rc_g == '0)); // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd6) |-> (out_valid == $past(in_valid, 6))); // R2

    AST_K_DIGIT_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (g_add(g_mul(k_quot[5:0], MA_G), k6_q.rk) == k6_q.res)); // R4

    AST_R_DIGIT_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (g_add(g_mul(r_quot[5:0], MA_G), r6_q.rk) == r6_q.res)); // R5

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (k_quot >> G_BITS) == '0 && (r_quot >> G_BITS) == '0); // R6

endmodule

// File: tb/gchan_compress_tb.sv
module gchan_compress_tb_top;
    localparam int              W      = 16;
    localparam int              NA     = 3;
    localparam logic [NA*W-1:0] MODULI = {16'd65497, 16'd65519, 16'd65521};
    localparam logic [5:0]      SIGMA0 = 6'd0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [NA*W-1:0] k_xi = '0, r_xi = '0;
    logic [5:0]      k_g = '0, r_g = '0;
    logic            out_valid;
    logic [W-1:0]    k_quot, r_quot;
    logic [5:0]      kc_g, rc_g;

    always #2.5 clk = ~clk;

    gchan_compress #(.W(W), .NA(NA), .MODULI(MODULI), .SIGMA0(SIGMA0)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .k_xi(k_xi), .k_g(k_g), .r_xi(r_xi), .r_g(r_g),
        .out_valid(out_valid), .k_quot(k_quot), .r_quot(r_quot),
        .kc_g(kc_g), .rc_g(rc_g)
    );

    typedef struct {
        longint kk, kr, kc, rc;
        int     stamp;
        bit     short_k;
    } exp_t;

    exp_t   expq[$];
    int     checks = 0, fails = 0, cyc = 0;
    bit     done = 0;
    longint m_l [NA];
    longint cof_l [NA];
    longint inv_l [NA];
    longint ma_l;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic longint pow_mod(input longint b, input longint e, input longint m);
        longint r = 1, x = b % m, k = e;
        while (k > 0) begin
            if (k[0]) r = (r * x) % m;
            x = (x * x) % m;
            k = k >> 1;
        end
        return r;
    endfunction

    // reference for one operand: scaled residues, extended residue, digit, estimate shortfall
    task automatic lane_ref(input longint v, output logic [NA*W-1:0] xi,
                            output longint rkhat, output longint digit, output longint d);
        longint s = 0, tops = 0, xv, qx, qh;
        for (int i = 0; i < NA; i++) begin
            xv = ((v % m_l[i]) * inv_l[i]) % m_l[i];
            xi[i*W +: W] = W'(xv);
            s    += xv * cof_l[i];
            tops += xv >> (W - 6);
        end
        qx    = s / ma_l;
        qh    = (longint'(SIGMA0) + tops) >> 6;
        d     = qx - qh;
        rkhat = (v % ma_l) + d * ma_l;
        digit = ((v / ma_l) - d) & 63;
    endtask

    task automatic send(input longint kv, input longint rv);
        exp_t e;
        logic [NA*W-1:0] kx, rx;
        longint rkk, rkr, dk, dr, qk, qr;
        lane_ref(kv, kx, rkk, qk, dk);
        lane_ref(rv, rx, rkr, qr, dr);
        e.kk = qk;
        e.kr = qr;
        e.kc = (qr + rkk) & 63;
        e.rc = (rkr + 2 * qk) & 63;
        e.stamp = cyc;
        e.short_k = (dk != 0);
        expq.push_back(e);
        k_xi = kx; k_g = 6'(kv & 63);
        r_xi = rx; r_g = 6'(rv & 63);
        in_valid = 1'b1;
    endtask

    // monitor at the falling edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check("R2 spurious output", 1'b0, 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check("R2 latency", (cyc - e.stamp) == 6, cyc - e.stamp, 6);
                check(e.short_k ? "R8 k digit after short estimate" : "R4 k digit",
                      k_quot[5:0] == 6'(e.kk), k_quot[5:0], e.kk);
                check("R5 r digit", r_quot[5:0] == 6'(e.kr), r_quot[5:0], e.kr);
                check("R6 zero pad", (k_quot >> 6) == 0 && (r_quot >> 6) == 0,
                      longint'(k_quot >> 6) + longint'(r_quot >> 6), 0);
                check("R7 kc lane (R3 extension)", kc_g == 6'(e.kc), kc_g, e.kc);
                check("R7 rc lane", rc_g == 6'(e.rc), rc_g, e.rc);
            end
        end
    end

    initial begin
        longint lim;
        void'($urandom(32'h6c0de));
        ma_l = 1;
        for (int i = 0; i < NA; i++) begin
            m_l[i] = longint'(MODULI[i*W +: W]);
            ma_l  *= m_l[i];
        end
        for (int i = 0; i < NA; i++) begin
            cof_l[i] = ma_l / m_l[i];
            inv_l[i] = pow_mod(cof_l[i] % m_l[i], m_l[i] - 2, m_l[i]);
        end
        lim = 63 * ma_l;

        repeat (4) @(negedge clk);
        check("R1 reset valid", out_valid == 1'b0, out_valid, 0);
        check("R1 reset digits", k_quot == 0 && r_quot == 0 && kc_g == 0 && rc_g == 0,
              longint'(k_quot) + r_quot + kc_g + rc_g, 0);
        rst = 1'b0;

        // directed boundaries; K = 1 forces the short estimate and the wrap to 63 (R8)
        @(negedge clk); send(0, 0);
        @(negedge clk); send(1, lim - 1);
        @(negedge clk); send(ma_l - 1, ma_l);
        @(negedge clk); send(ma_l, 1);
        @(negedge clk); send(lim - 1, 0);
        @(negedge clk); send(62 * ma_l, ma_l - 1);
        @(negedge clk); in_valid = 1'b0;

        // random stream with idle gaps
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if ($urandom_range(3) != 0) begin
                longint a, b;
                a = {$urandom, $urandom};
                b = {$urandom, $urandom};
                if (a < 0) a = -a;
                if (b < 0) b = -b;
                send(a % lim, b % lim);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 all results delivered", expq.size() == 0, expq.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule